// File: doc/BRIEF.md
# BCD Time and Calendar Counter

This block keeps wall-clock time and calendar date as packed BCD bytes: seconds, minutes, hours, weekday, date of month, month with a century flag, and a two-digit year. A clock-enable input pulsing at the nominal 32.768 kHz rate drives a binary sub-second prescaler. Each time the prescaler wraps, the time advances by one second, and carries propagate up through the whole calendar. The calendar handles months of 28, 29, 30 and 31 days and applies the leap-year rule for years 00 through 99.

A host sets any field through a byte-wide load port that takes a field selector. A write to the seconds field restarts the prescaler from zero. This fixes the phase of both the next second increment and the 1 Hz square-wave output, which is the prescaler's top bit. A halt input freezes the prescaler. A sticky status flag records that the oscillator stopped: it comes up set after reset and is set again each time the halt input rises. Software clears it by writing 0, and writing 1 to it changes nothing.

Top module: `rtc_calendar`

## Requirements
- R1: After reset the fields read seconds 00, minutes 00, hours 00 in 24-hour mode, weekday 1, date 01, month 01 with century 0, and year 00. The stop flag reads 1 and the square wave reads 0.
- R2: Seconds and minutes count 00 to 59 in BCD. The step from 59 returns the field to 00 and carries into the next field.
- R3: With hours bit 6 at 0 (24-hour mode), hours count 00 to 23 in BCD. Bit 5 holds the twenties digit. The step from 23 goes to 00 and advances the weekday and the date.
- R4: With hours bit 6 at 1 (12-hour mode), bits 4:0 hold the hour 01 to 12 in BCD and bit 5 is the PM flag. The step from 11 goes to 12 and inverts PM, and the step from 12 goes to 01. The day advances only on the step from 11 PM to 12 AM.
- R5: The weekday counts 1 to 7 and goes from 7 back to 1 when the day advances.
- R6: The date goes back to 01 and the month advances after day 30 in months 04, 06, 09 and 11, and after day 31 in the other months except 02. Month 12 is followed by month 01.
- R7: February ends after day 29 when the BCD year is divisible by 4 (odd tens digit with ones digit 2 or 6, or even tens digit with ones digit 0, 4 or 8), and after day 28 otherwise.
- R8: Month bit 7 is the century flag. It inverts when the year wraps from 99 to 00.
- R9: A write to the seconds field resets the prescaler of 2^PRE_BITS enables. The square wave reads 0 until 2^(PRE_BITS-1) enables have passed, then reads 1, and the seconds advance after 2^PRE_BITS enables.
- R10: While the halt input is 1, enable pulses do not advance the prescaler or any time field.
- R11: The stop flag is set when the halt input rises. A flag write with data 0 clears it, and a flag write with data 1 leaves it unchanged.
- R12: Load-port selector codes are 0 seconds, 1 minutes, 2 hours, 3 weekday, 4 date, 5 month, 6 year, and code 7 is ignored. Stored bytes are masked to the field width: weekday keeps bits 2:0, date keeps bits 5:0, month keeps bits 7 and 4:0, and seconds, minutes and hours keep bits 6:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick32k | input | 1 | Prescaler clock enable at the nominal 32.768 kHz rate |
| oscHalt | input | 1 | 1 freezes the prescaler |
| wrEn | input | 1 | Load-port write strobe |
| wrSel | input | 3 | Field selector for the load port |
| wrData | input | 8 | BCD byte to load |
| flagWr | input | 1 | Stop-flag write strobe |
| flagData | input | 1 | Value written to the stop flag (only 0 has an effect) |
| seconds | output | 8 | Seconds, BCD |
| minutes | output | 8 | Minutes, BCD |
| hours | output | 8 | Hours byte with mode and PM/twenties bits |
| weekday | output | 8 | Day of week 1 to 7 |
| date | output | 8 | Date of month, BCD |
| month | output | 8 | Month in BCD with the century flag in bit 7 |
| year | output | 8 | Year 00 to 99, BCD |
| sqw1Hz | output | 1 | 1 Hz square wave, 50% duty |
| oscStopFlag | output | 1 | Sticky oscillator-stopped flag |

## Verification
The bench drives the clock to the last second of the hour, the day, the month and the year, and checks the next second. February is tested in a year divisible by 4, in year 00 and in year 10. A leap test that read only the ones digit would give year 10 a 29th day. A counter that treated every short month alike would roll 30 April to 31 April. The 12-hour checks cover 11 AM, 11 PM and 12 PM: a design that toggled PM on the step from 12 to 1, or advanced the day at noon, shows the wrong hour byte or weekday. The bench also writes the seconds field partway through a second and checks the square-wave level and the seconds value at the enable count where a prescaler that was not restarted would already have wrapped.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  typedef enum logic [2:0] {
    FLD_SEC   = 3'd0,
    FLD_MIN   = 3'd1,
    FLD_HOUR  = 3'd2,
    FLD_DAY   = 3'd3,
    FLD_DATE  = 3'd4,
    FLD_MONTH = 3'd5,
    FLD_YEAR  = 3'd6,
    FLD_NONE  = 3'd7
  } fieldSel_e;

  // Strobes from control to datapath; advance and load never coincide.
  typedef struct packed {
    logic       advance;
    logic       load;
    logic [2:0] loadSel;
    logic [7:0] loadData;
  } dpStrobe_t;

  function automatic logic [7:0] bcdInc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

endpackage

// File: rtl/rtc_ctrl.sv
module rtc_ctrl
  import rtc_pkg::*;
#(
  parameter int PRE_BITS = 15
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick32k,
  input  logic       oscHalt,
  input  logic       wrEn,
  input  logic [2:0] wrSel,
  input  logic [7:0] wrData,
  input  logic       flagWr,
  input  logic       flagData,
  output dpStrobe_t  strobe,
  output logic       sqwOut,
  output logic       stopFlag
);

  localparam logic [PRE_BITS-1:0] PRE_MAX = {PRE_BITS{1'b1}};

  logic [PRE_BITS-1:0] preCnt;
  logic                tickPend;
  logic                haltQ;
  logic                secWr;
  logic                advance;

  assign secWr   = wrEn && (wrSel == FLD_SEC);
  // A pending second waits one cycle if the host is loading a field.
  assign advance = tickPend && !wrEn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt   <= '0;
      tickPend <= 1'b0;
      haltQ    <= 1'b0;
      stopFlag <= 1'b1;
    end else begin
      haltQ <= oscHalt;
      if (secWr) begin
        preCnt   <= '0;
        tickPend <= 1'b0;
      end else begin
        if (advance) tickPend <= 1'b0;
        if (tick32k && !oscHalt) begin
          preCnt <= preCnt + 1'b1;
          if (preCnt == PRE_MAX) tickPend <= 1'b1;
        end
      end
      if (oscHalt && !haltQ)        stopFlag <= 1'b1;
      else if (flagWr && !flagData) stopFlag <= 1'b0;
    end
  end

  assign sqwOut = preCnt[PRE_BITS-1];

  always_comb begin
    strobe.advance  = advance;
    strobe.load     = wrEn;
    strobe.loadSel  = wrSel;
    strobe.loadData = wrData;
  end

  // R9
  sec_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    secWr |=> (!sqwOut && !strobe.advance));

  // R10
  halt_freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    (oscHalt && !secWr) |=> $stable(preCnt));

  // R11
  flag_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (oscHalt && !haltQ) |=> stopFlag);

  // R11
  flag_one_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flagWr && flagData && !stopFlag && !(oscHalt && !haltQ)) |=> !stopFlag);

endmodule

// File: rtl/rtc_datapath.sv
module rtc_datapath
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  dpStrobe_t  strobe,
  output logic [7:0] secOut,
  output logic [7:0] minOut,
  output logic [7:0] hrOut,
  output logic [7:0] dayOut,
  output logic [7:0] dateOut,
  output logic [7:0] monOut,
  output logic [7:0] yearOut
);

  logic [7:0] secR, minR, hrR, dateR, monR, yearR;
  logic [2:0] dayR;

  logic [7:0] secInc, minInc, hrIncIn, hrInc, dateInc, monInc, yearInc;
  logic [7:0] hrNext, lastDate;
  logic       secWrap, minWrap, dateWrap, monWrap, yearWrap;
  logic       dayCarry, isLeap;
  logic       cMin, cHour, cDay, cMon, cYear;

  assign secInc  = bcdInc(secR);
  assign minInc  = bcdInc(minR);
  assign hrIncIn = hrR[6] ? {3'b000, hrR[4:0]} : {2'b00, hrR[5:0]};
  assign hrInc   = bcdInc(hrIncIn);
  assign dateInc = bcdInc(dateR);
  assign monInc  = bcdInc({1'b0, monR[6:0]});
  assign yearInc = bcdInc(yearR);

  assign secWrap  = (secR == 8'h59);
  assign minWrap  = (minR == 8'h59);
  assign dateWrap = (dateR == lastDate);
  assign monWrap  = (monR[4:0] == 5'h12);
  assign yearWrap = (yearR == 8'h99);

  // Divisible by 4 in BCD: tens parity decides which ones digits qualify.
  always_comb begin
    if (yearR[4]) isLeap = (yearR[3:0] == 4'd2) || (yearR[3:0] == 4'd6);
    else          isLeap = (yearR[3:0] == 4'd0) || (yearR[3:0] == 4'd4) ||
                           (yearR[3:0] == 4'd8);
  end

  always_comb begin
    case (monR[4:0])
      5'h02:                      lastDate = isLeap ? 8'h29 : 8'h28;
      5'h04, 5'h06, 5'h09, 5'h11: lastDate = 8'h30;
      default:                    lastDate = 8'h31;
    endcase
  end

  always_comb begin
    hrNext   = hrR;
    dayCarry = 1'b0;
    if (hrR[6]) begin
      if (hrR[4:0] == 5'h12) begin
        hrNext = {2'b01, hrR[5], 5'h01};
      end else if (hrR[4:0] == 5'h11) begin
        hrNext   = {2'b01, ~hrR[5], 5'h12};
        dayCarry = hrR[5];
      end else begin
        hrNext = {2'b01, hrR[5], hrInc[4:0]};
      end
    end else if (hrR[5:0] == 6'h23) begin
      hrNext   = 8'h00;
      dayCarry = 1'b1;
    end else begin
      hrNext = hrInc;
    end
  end

  assign cMin  = strobe.advance && secWrap;
  assign cHour = cMin && minWrap;
  assign cDay  = cHour && dayCarry;
  assign cMon  = cDay && dateWrap;
  assign cYear = cMon && monWrap;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      secR  <= 8'h00;
      minR  <= 8'h00;
      hrR   <= 8'h00;
      dayR  <= 3'd1;
      dateR <= 8'h01;
      monR  <= 8'h01;
      yearR <= 8'h00;
    end else if (strobe.load) begin
      case (strobe.loadSel)
        FLD_SEC:   secR  <= strobe.loadData & 8'h7F;
        FLD_MIN:   minR  <= strobe.loadData & 8'h7F;
        FLD_HOUR:  hrR   <= strobe.loadData & 8'h7F;
        FLD_DAY:   dayR  <= strobe.loadData[2:0];
        FLD_DATE:  dateR <= strobe.loadData & 8'h3F;
        FLD_MONTH: monR  <= strobe.loadData & 8'h9F;
        FLD_YEAR:  yearR <= strobe.loadData;
        default:   ;
      endcase
    end else if (strobe.advance) begin
      secR <= secWrap ? 8'h00 : secInc;
      if (cMin)  minR  <= minWrap ? 8'h00 : minInc;
      if (cHour) hrR   <= hrNext;
      if (cDay) begin
        dayR  <= (dayR == 3'd7) ? 3'd1 : dayR + 3'd1;
        dateR <= dateWrap ? 8'h01 : dateInc;
      end
      if (cMon) begin
        if (monWrap) monR <= {monR[7] ^ yearWrap, 7'h01};
        else         monR <= monInc | {monR[7], 7'h00};
      end
      if (cYear) yearR <= yearWrap ? 8'h00 : yearInc;
    end
  end

  assign secOut  = secR;
  assign minOut  = minR;
  assign hrOut   = hrR;
  assign dayOut  = {5'b00000, dayR};
  assign dateOut = dateR;
  assign monOut  = monR;
  assign yearOut = yearR;

  // R2
  min_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && !secWrap) |=> $stable(minR));

  // R5
  weekday_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cDay && dayR == 3'd7) |=> (dayR == 3'd1));

  // R7
  leap_feb_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cDay && monR[4:0] == 5'h02 && dateR == 8'h28 && isLeap) |=> (dateR == 8'h29));

  // R8
  century_flip_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cYear && yearWrap) |=> (monR[7] != $past(monR[7])));

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
#(
  parameter int PRE_BITS = 15
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick32k,
  input  logic       oscHalt,
  input  logic       wrEn,
  input  logic [2:0] wrSel,
  input  logic [7:0] wrData,
  input  logic       flagWr,
  input  logic       flagData,
  output logic [7:0] seconds,
  output logic [7:0] minutes,
  output logic [7:0] hours,
  output logic [7:0] weekday,
  output logic [7:0] date,
  output logic [7:0] month,
  output logic [7:0] year,
  output logic       sqw1Hz,
  output logic       oscStopFlag
);

  dpStrobe_t strobe;

  rtc_ctrl #(.PRE_BITS(PRE_BITS)) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .tick32k  (tick32k),
    .oscHalt  (oscHalt),
    .wrEn     (wrEn),
    .wrSel    (wrSel),
    .wrData   (wrData),
    .flagWr   (flagWr),
    .flagData (flagData),
    .strobe   (strobe),
    .sqwOut   (sqw1Hz),
    .stopFlag (oscStopFlag)
  );

  rtc_datapath i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .secOut  (seconds),
    .minOut  (minutes),
    .hrOut   (hours),
    .dayOut  (weekday),
    .dateOut (date),
    .monOut  (month),
    .yearOut (year)
  );

  // R1
  reset_flag_chk: assert property (@(posedge clk)
    !rstN |=> oscStopFlag);

endmodule

// File: tb/test_rtc_calendar.sv
module test_rtc_calendar;

  localparam int PB  = 4;
  localparam int SEC = 1 << PB;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tick32k = 1'b0;
  logic       oscHalt = 1'b0;
  logic       wrEn = 1'b0;
  logic [2:0] wrSel = 3'd0;
  logic [7:0] wrData = 8'h00;
  logic       flagWr = 1'b0;
  logic       flagData = 1'b0;
  logic [7:0] seconds, minutes, hours, weekday, date, month, year;
  logic       sqw1Hz, oscStopFlag;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int         selQ[$];
  logic [7:0] valQ[$];
  string      tagQ[$];
  event       chkEv;

  always #5 clk = ~clk;

  rtc_calendar #(.PRE_BITS(PB)) i_rtc_calendar (
    .clk(clk), .rstN(rstN), .tick32k(tick32k), .oscHalt(oscHalt),
    .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .flagWr(flagWr), .flagData(flagData),
    .seconds(seconds), .minutes(minutes), .hours(hours), .weekday(weekday),
    .date(date), .month(month), .year(year),
    .sqw1Hz(sqw1Hz), .oscStopFlag(oscStopFlag)
  );

  // observe codes: 0..6 fields as selector, 7 square wave, 8 stop flag
  function automatic logic [7:0] observe(int sel);
    case (sel)
      0: return seconds;
      1: return minutes;
      2: return hours;
      3: return weekday;
      4: return date;
      5: return month;
      6: return year;
      7: return {7'd0, sqw1Hz};
      default: return {7'd0, oscStopFlag};
    endcase
  endfunction

  // monitor: pops expected items and compares with the outputs
  initial begin
    forever begin
      @(chkEv);
      while (selQ.size() != 0) begin
        int s;
        logic [7:0] v, got;
        string t;
        s = selQ.pop_front();
        v = valQ.pop_front();
        t = tagQ.pop_front();
        got = observe(s);
        checks++;
        if (got !== v) begin
          errors++;
          $display("FAIL %s: observe %0d actual %02h expected %02h", t, s, got, v);
        end
      end
    end
  end

  task automatic expectVal(int sel, logic [7:0] val, string tag);
    selQ.push_back(sel);
    valQ.push_back(val);
    tagQ.push_back(tag);
  endtask

  task automatic flush();
    ->chkEv;
    #1;
  endtask

  task automatic wr(logic [2:0] sel, logic [7:0] data);
    @(negedge clk);
    wrEn = 1'b1; wrSel = sel; wrData = data;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic flagWrite(logic d);
    @(negedge clk);
    flagWr = 1'b1; flagData = d;
    @(negedge clk);
    flagWr = 1'b0;
  endtask

  task automatic runEn(int n);
    @(negedge clk);
    tick32k = 1'b1;
    repeat (n) @(negedge clk);
    tick32k = 1'b0;
    @(negedge clk);
  endtask

  task automatic setAll(logic [7:0] s, logic [7:0] m, logic [7:0] h, logic [7:0] d,
                        logic [7:0] dt, logic [7:0] mo, logic [7:0] y);
    wr(3'd1, m); wr(3'd2, h); wr(3'd3, d); wr(3'd4, dt);
    wr(3'd5, mo); wr(3'd6, y); wr(3'd0, s);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run hung, actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    expectVal(0, 8'h00, "R1 sec"); expectVal(1, 8'h00, "R1 min");
    expectVal(2, 8'h00, "R1 hour"); expectVal(3, 8'h01, "R1 day");
    expectVal(4, 8'h01, "R1 date"); expectVal(5, 8'h01, "R1 month");
    expectVal(6, 8'h00, "R1 year"); expectVal(8, 8'h01, "R1 flag");
    expectVal(7, 8'h00, "R1 sqw");
    flush();

    // R11 clear by 0, write of 1 ignored
    flagWrite(1'b0);
    expectVal(8, 8'h00, "R11 clear"); flush();
    flagWrite(1'b1);
    expectVal(8, 8'h00, "R11 write one"); flush();

    // R9 square-wave phase after seconds write
    wr(3'd0, 8'h10);
    runEn(SEC/2 - 1);
    expectVal(7, 8'h00, "R9 sqw low"); flush();
    runEn(1);
    expectVal(7, 8'h01, "R9 sqw high"); expectVal(0, 8'h10, "R9 sec held"); flush();
    runEn(SEC/2);
    expectVal(0, 8'h11, "R9 sec step"); expectVal(7, 8'h00, "R9 sqw fall"); flush();
    runEn(5);
    wr(3'd0, 8'h20);
    runEn(SEC - 5);
    expectVal(0, 8'h20, "R9 restart sec"); expectVal(7, 8'h01, "R9 restart sqw"); flush();

    // R10 halt and R11 set on halt
    @(negedge clk); oscHalt = 1'b1;
    @(negedge clk);
    expectVal(8, 8'h01, "R11 halt sets flag"); flush();
    runEn(2 * SEC);
    expectVal(0, 8'h20, "R10 halted sec"); expectVal(7, 8'h01, "R10 halted sqw"); flush();
    @(negedge clk); oscHalt = 1'b0;
    flagWrite(1'b0);

    // R12 masking and ignored selector
    wr(3'd3, 8'hFF);
    expectVal(3, 8'h07, "R12 day mask"); flush();
    wr(3'd7, 8'h55);
    expectVal(0, 8'h20, "R12 sel7 sec"); expectVal(6, 8'h00, "R12 sel7 year");
    expectVal(3, 8'h07, "R12 sel7 day"); flush();

    // R2 R3 R5 end of day, non-leap February (R7)
    setAll(8'h59, 8'h59, 8'h23, 8'h07, 8'h28, 8'h02, 8'h23);
    runEn(SEC);
    expectVal(0, 8'h00, "R2 sec"); expectVal(1, 8'h00, "R2 min");
    expectVal(2, 8'h00, "R3 hour"); expectVal(3, 8'h01, "R5 day");
    expectVal(4, 8'h01, "R7 date"); expectVal(5, 8'h03, "R7 month"); flush();

    // R7 leap year 24
    setAll(8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h24);
    runEn(SEC);
    expectVal(4, 8'h29, "R7 leap 24"); expectVal(5, 8'h02, "R7 leap 24 month");
    expectVal(3, 8'h03, "R5 day inc"); flush();
    setAll(8'h59, 8'h59, 8'h23, 8'h02, 8'h29, 8'h02, 8'h24);
    runEn(SEC);
    expectVal(4, 8'h01, "R7 leap end"); expectVal(5, 8'h03, "R7 leap end month"); flush();
    // R7 year 00 and year 10
    setAll(8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h00);
    runEn(SEC);
    expectVal(4, 8'h29, "R7 year 00"); flush();
    setAll(8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h10);
    runEn(SEC);
    expectVal(4, 8'h01, "R7 year 10"); expectVal(5, 8'h03, "R7 year 10 month"); flush();

    // R6 30- and 31-day months
    setAll(8'h59, 8'h59, 8'h23, 8'h02, 8'h30, 8'h04, 8'h31);
    runEn(SEC);
    expectVal(4, 8'h01, "R6 april"); expectVal(5, 8'h05, "R6 april month"); flush();
    setAll(8'h59, 8'h59, 8'h23, 8'h02, 8'h30, 8'h05, 8'h31);
    runEn(SEC);
    expectVal(4, 8'h31, "R6 may"); flush();

    // R8 year wrap with century toggle
    setAll(8'h59, 8'h59, 8'h23, 8'h02, 8'h31, 8'h12, 8'h99);
    runEn(SEC);
    expectVal(5, 8'h81, "R8 century"); expectVal(6, 8'h00, "R8 year");
    expectVal(4, 8'h01, "R6 december"); flush();

    // R4 12-hour mode
    setAll(8'h59, 8'h59, 8'h51, 8'h03, 8'h10, 8'h01, 8'h05);
    runEn(SEC);
    expectVal(2, 8'h72, "R4 11AM to 12PM"); expectVal(3, 8'h03, "R4 noon day"); flush();
    setAll(8'h59, 8'h59, 8'h72, 8'h03, 8'h10, 8'h01, 8'h05);
    runEn(SEC);
    expectVal(2, 8'h61, "R4 12PM to 1PM"); flush();
    setAll(8'h59, 8'h59, 8'h71, 8'h03, 8'h10, 8'h01, 8'h05);
    runEn(SEC);
    expectVal(2, 8'h52, "R4 11PM to 12AM"); expectVal(3, 8'h04, "R4 midnight day");
    expectVal(4, 8'h11, "R4 midnight date"); flush();
    setAll(8'h59, 8'h59, 8'h52, 8'h03, 8'h10, 8'h01, 8'h05);
    runEn(SEC);
    expectVal(2, 8'h41, "R4 12AM to 1AM"); flush();

    done = 1;
    summary();
    $finish;
  end

endmodule